// File: doc/BRIEF.md
# Strap-Addressed Module Description Memory Target on I2C

This block is a two-wire bus target that stands in for the small description memory found on a memory module. A host reads bytes from it to learn the module's layout and timing. The host first writes a one-byte location pointer. It then reads from that pointer, one byte or many in a row.

The memory answers at a 7-bit address whose upper four bits are fixed at `1010`. Three strap pins set the low three bits. Board-level pull-downs make an unstrapped part answer at 0x50. A second address, 0x30, is a write-only control port.

A protect pin controls data writes. While it is high, both addresses still acknowledge their address byte and their first byte. Every byte after that is refused, and the memory array keeps its contents. While the pin is low, data bytes to the memory address are stored in turn at the pointer. Data bytes to the control address are acknowledged and discarded.

The bus pins are open-drain. Each line enters through an input pin, and the block pulls SDA low through a separate pull-enable output. The block never stretches SCL.

Top module: `spd_i2c_target`

## Requirements
- R1: The memory address is {4'b1010, strap_i[2:0]} (address bit 6 first on the wire, then the R/W bit, 1 = read). A matching address byte is acknowledged by pulling SDA low during the ninth clock, for both directions.
- R2: Any address byte that is neither the memory address nor a write to 0x30 is not acknowledged. The block then leaves SDA released and ignores every byte until the next START, so no memory byte and no pointer value changes.
- R3: A write to the memory address loads its first data byte into the pointer. A following read returns the byte at that pointer, most significant bit first.
- R4: During a read the pointer advances by one after each byte, rolling over from 255 to 0. The block keeps sending bytes while the host acknowledges them and stops driving once the host does not.
- R5: After reset, location 0 holds 0x80, location 1 holds 0x08, location 2 holds 0x04, and every other location i holds the value i.
- R6: With wp_i high, the address byte and the pointer byte of a memory write are acknowledged. Every later byte is not acknowledged and memory is unchanged.
- R7: With wp_i low, each byte after the pointer byte is stored at the pointer and acknowledged, and the pointer then advances, rolling over from 255 to 0.
- R8: Address 0x30 acknowledges writes only; a read at 0x30 is not acknowledged. Bytes written to 0x30 never change memory or the pointer. Its first byte is always acknowledged. Later bytes are refused while wp_i is high and acknowledged while it is low.
- R9: SCL, SDA and wp_i pass through two-flop synchronisers. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The block changes its SDA drive only while SCL is low.
- R10: The pointer keeps its value between transactions. A read with no pointer write continues from where the last access left it.
- R11: During reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| strap_i | input | 3 | Low three bits of the memory address; tie low when unused |
| wp_i | input | 1 | Write protect, 1 = refuse data bytes |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
Two pairs of events can land in one cycle.

The first pair is a data byte being stored at location 255 and the pointer rolling over to 0. Directed writes and reads start at pointers 254 and 255, and random transactions use random pointers. The result is judged by reading back both ends of the array, plus the byte the pointer returns next.

The second pair is the protect decision and the ninth-clock acknowledge of a data byte. The protect pin is toggled at random between transactions at both addresses. The acknowledge bit and the later read-back are compared with a bench model that stores data only when protection is off.

// File: rtl/spd_pkg.sv
// Shared types and reset contents for the description-memory target.
// Assumes a byte-wide array addressed by a pointer of at most 8 bits.
package spd_pkg;

    // Link-layer phases of one bus transaction
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } link_st_t;

    // Which of the two addresses the current transaction selected
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_MEM,
        TGT_CTL
    } target_t;

    // Reset contents: three header bytes, then each location holds its own index
    function automatic logic [7:0] preload_byte(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h04;
            default: return 8'(idx);
        endcase
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
// Multi-stage synchroniser for asynchronous level inputs.
// Assumes inputs are quasi-static with respect to clk (bus lines, straps of protection).
module spd_line_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    // First stage captures the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end

    // Remaining stages shift the sample along
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spd_bus_events.sv
// Turns synchronised SCL/SDA levels into one-cycle event pulses:
// SCL rising, SCL falling, START and STOP.
// Assumes both inputs come from the same synchroniser so they stay aligned.
module spd_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic scl_d;
    logic sda_d;

    // Hold last cycle's levels; idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode from current and previous levels
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_p  = scl_s & scl_d & sda_d & ~sda_s;
        stop_p   = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/spd_store.sv
// Byte array with its location pointer. Contents come from the package
// preload function at reset. Assumes at most one of load, write, advance per cycle.
module spd_store #(
    parameter int DEPTH = 256,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             ptr_inc,
    output logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr
);

    logic [7:0] mem [DEPTH];

    // Array: preload on reset, otherwise store one byte at the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= spd_pkg::preload_byte(i);
            end
        end else if (wr_en) begin
            mem[ptr] <= wr_data;
        end
    end

    // Pointer: load from host, advance after each stored or sent byte, wrap naturally
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (ptr_load)         ptr <= ptr_val;
        else if (wr_en || ptr_inc) ptr <= ptr + 1'b1;
    end

    assign rd_data = mem[ptr];

endmodule

// File: rtl/spd_link_fsm.sv
// Bit and byte sequencer of the target: address decode, acknowledge policy,
// write-protect gating and serial read-out. Assumes SCL low phases last
// several clk cycles so SDA updates settle before SCL rises.
module spd_link_fsm #(
    parameter logic [6:0] MEM_BASE = 7'h50,
    parameter logic [6:0] CTL_ADDR = 7'h30,
    parameter int         PTR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             sda_s,
    input  logic             wp_s,
    input  logic [2:0]       strap,
    input  logic [7:0]       rd_data,
    output logic             ptr_load,
    output logic [PTR_W-1:0] ptr_val,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             ptr_inc,
    output logic             sda_pull
);

    import spd_pkg::*;

    link_st_t   state;
    target_t    tgt;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rd_mode;
    logic       first_byte;
    logic       host_ack;

    logic [6:0] mem_addr;
    logic       hit_mem;
    logic       hit_ctl;
    logic       byte_end;
    logic       accept_byte;

    // Address match and byte-boundary decode
    always_comb begin
        mem_addr    = {MEM_BASE[6:3], strap};
        hit_mem     = (rx_sh[7:1] == mem_addr);
        hit_ctl     = (rx_sh[7:1] == CTL_ADDR) && !rx_sh[0];
        byte_end    = scl_fall && (bit_cnt == 4'd8);
        accept_byte = first_byte || !wp_s;
    end

    // Strobes to the array: pointer load, byte store, read advance
    always_comb begin
        ptr_load = (state == ST_WR) && byte_end && first_byte && (tgt == TGT_MEM);
        wr_en    = (state == ST_WR) && byte_end && !first_byte && (tgt == TGT_MEM) && !wp_s;
        ptr_inc  = (state == ST_RD) && byte_end;
        ptr_val  = rx_sh[PTR_W-1:0];
        wr_data  = rx_sh;
    end

    // Transaction sequencer; START and STOP override any phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tgt        <= TGT_NONE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rd_mode    <= 1'b0;
            first_byte <= 1'b0;
            host_ack   <= 1'b0;
            sda_pull   <= 1'b0;
        end else if (start_p) begin
            state    <= ST_ADDR;
            tgt      <= TGT_NONE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (stop_p) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sda_pull <= 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        if (hit_mem) begin
                            tgt      <= TGT_MEM;
                            rd_mode  <= rx_sh[0];
                            sda_pull <= 1'b1;
                            state    <= ST_ADDR_ACK;
                        end else if (hit_ctl) begin
                            tgt      <= TGT_CTL;
                            rd_mode  <= 1'b0;
                            sda_pull <= 1'b1;
                            state    <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt    <= '0;
                        first_byte <= 1'b1;
                        if (rd_mode) begin
                            tx_sh    <= rd_data;
                            sda_pull <= !rd_data[7];
                            state    <= ST_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        sda_pull   <= accept_byte;
                        first_byte <= 1'b0;
                        state      <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        sda_pull <= 1'b0;
                        state    <= ST_RD_ACK;
                    end else if (scl_fall && bit_cnt != 4'd0) begin
                        sda_pull <= !tx_sh[6];
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_ack <= !sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            tx_sh    <= rd_data;
                            sda_pull <= !rd_data[7];
                            bit_cnt  <= '0;
                            state    <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state    <= ST_IDLE;
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/spd_i2c_target.sv
// Top of the strap-addressed description-memory target. Synchronises the
// bus and protect pins, derives bus events, sequences transactions and
// holds the array. Assumes clk runs at least 16x faster than SCL.
module spd_i2c_target #(
    parameter logic [6:0] MEM_BASE    = 7'h50,
    parameter logic [6:0] CTL_ADDR    = 7'h30,
    parameter int         DEPTH       = 256,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [1:0]       bus_s;
    logic             scl_s;
    logic             sda_s;
    logic             wp_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_p;
    logic             stop_p;
    logic             ptr_load;
    logic [PTR_W-1:0] ptr_val;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic             ptr_inc;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] ptr;
    logic             sda_pull;

    spd_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (bus_s)
    );

    spd_line_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wp_i),
        .q     (wp_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    spd_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    spd_link_fsm #(.MEM_BASE(MEM_BASE), .CTL_ADDR(CTL_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .sda_s    (sda_s),
        .wp_s     (wp_s),
        .strap    (strap_i),
        .rd_data  (rd_data),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr_inc  (ptr_inc),
        .sda_pull (sda_pull)
    );

    spd_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr_inc  (ptr_inc),
        .rd_data  (rd_data),
        .ptr      (ptr)
    );

    assign sda_pull_o = sda_pull;

endmodule

// File: rtl/spd_i2c_target_chk.sv
// Property checker for the target, attached by bind. Observes the
// synchronised bus, the protect level, array strobes and the pointer.
module spd_i2c_target_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_pull,
    input logic             wp_s,
    input logic             wr_en,
    input logic             ptr_inc,
    input logic             ptr_load,
    input logic [PTR_W-1:0] ptr,
    input logic             start_p,
    input logic             stop_p,
    input logic             scl_rise,
    input logic             scl_fall
);

    // R9: the SDA drive only moves while the synchronised SCL is low
    assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    // R9: bus events are mutually exclusive
    assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p, scl_rise, scl_fall}));

    // R6: no array store while protection is seen active
    assert_no_store_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wp_s);

    // R7: a store advances the pointer by one
    assert_store_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R7: load, store and read advance never coincide
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, ptr_inc, ptr_load}));

    // R4: advancing from the top location wraps to zero
    assert_ptr_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr_inc || wr_en) && (ptr == '1)) |=> (ptr == '0));

endmodule

bind spd_i2c_target spd_i2c_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_pull (sda_pull),
    .wp_s     (wp_s),
    .wr_en    (wr_en),
    .ptr_inc  (ptr_inc),
    .ptr_load (ptr_load),
    .ptr      (ptr),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
);

// File: tb/tb_spd_i2c_target.sv
// Bench for the description-memory target: bus-level controller tasks,
// a byte model of the array and pointer, directed corners and seeded random traffic.
module tb_spd_i2c_target;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       tb_pull;
    logic [2:0] strap;
    logic       wp;
    logic       dut_pull;
    logic       sda_line;

    always #2 clk = ~clk;

    assign sda_line = !(tb_pull | dut_pull);

    spd_i2c_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .wp_i       (wp),
        .sda_pull_o (dut_pull)
    );

    int         total = 0;
    int         bad = 0;
    bit         finished = 0;
    logic [7:0] model [256];
    int         mptr;
    logic [7:0] wbuf [8];

    // Reset contents as the requirements state them
    function automatic logic [7:0] exp_reset(input int i);
        if (i == 0) return 8'h80;
        if (i == 1) return 8'h08;
        if (i == 2) return 8'h04;
        return i[7:0];
    endfunction

    function automatic logic [6:0] mem_addr();
        return {4'b1010, strap};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qtr();
        repeat (8) @(negedge clk);
    endtask

    task automatic i2c_start();
        tb_pull = 1'b0; qtr();
        scl = 1'b1;     qtr();
        tb_pull = 1'b1; qtr();
        scl = 1'b0;     qtr();
    endtask

    task automatic i2c_stop();
        tb_pull = 1'b1; qtr();
        scl = 1'b1;     qtr();
        tb_pull = 1'b0; qtr(); qtr();
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) begin
            tb_pull = !b[k]; qtr();
            scl = 1'b1; qtr(); qtr();
            scl = 1'b0; qtr();
        end
        tb_pull = 1'b0; qtr();
        scl = 1'b1; qtr();
        ack = !sda_line; qtr();
        scl = 1'b0; qtr();
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        logic s1;
        for (int k = 7; k >= 0; k--) begin
            tb_pull = 1'b0; qtr();
            scl = 1'b1; qtr();
            s1 = sda_line; qtr();
            chk(sda_line == s1, "R9 SDA stable while SCL high", int'(sda_line), int'(s1));
            b[k] = s1;
            scl = 1'b0; qtr();
        end
        tb_pull = give_ack; qtr();
        scl = 1'b1; qtr(); qtr();
        scl = 1'b0; qtr();
        tb_pull = 1'b0;
    endtask

    // Write transaction: wbuf[0] is the first byte, nb bytes total
    task automatic do_write(input logic [6:0] a, input int nb);
        bit ack;
        bit is_mem;
        bit is_ctl;
        is_mem = (a == mem_addr());
        is_ctl = (a == 7'h30);
        i2c_start();
        write_byte({a, 1'b0}, ack);
        if (is_mem)      chk(ack == 1'b1, "R1 memory address write ack", int'(ack), 1);
        else if (is_ctl) chk(ack == 1'b1, "R8 control address write ack", int'(ack), 1);
        else             chk(ack == 1'b0, "R2 foreign address nack", int'(ack), 0);
        for (int k = 0; k < nb; k++) begin
            write_byte(wbuf[k], ack);
            if (!is_mem && !is_ctl)
                chk(ack == 1'b0, "R2 byte after foreign address nack", int'(ack), 0);
            else if (k == 0)
                chk(ack == 1'b1, is_mem ? "R6 pointer byte ack" : "R8 control first byte ack", int'(ack), 1);
            else if (wp)
                chk(ack == 1'b0, is_mem ? "R6 protected data nack" : "R8 protected control nack", int'(ack), 0);
            else
                chk(ack == 1'b1, is_mem ? "R7 data byte ack" : "R8 control data ack", int'(ack), 1);
            if (is_mem) begin
                if (k == 0) mptr = int'(wbuf[0]);
                else if (!wp) begin
                    model[mptr] = wbuf[k];
                    mptr = (mptr + 1) % 256;
                end
            end
        end
        i2c_stop();
    endtask

    // Read transaction, optionally preceded by a pointer write and repeated START
    task automatic do_read(input logic [6:0] a, input int n, input bit with_ptr,
                           input logic [7:0] p, input string tag);
        bit ack;
        logic [7:0] b;
        if (with_ptr) begin
            i2c_start();
            write_byte({mem_addr(), 1'b0}, ack);
            chk(ack == 1'b1, "R3 address ack before pointer", int'(ack), 1);
            write_byte(p, ack);
            chk(ack == 1'b1, "R3 pointer byte ack", int'(ack), 1);
            mptr = int'(p);
        end
        i2c_start();
        write_byte({a, 1'b1}, ack);
        if (a == mem_addr()) begin
            chk(ack == 1'b1, "R1 memory address read ack", int'(ack), 1);
            for (int k = 0; k < n; k++) begin
                read_byte(k != n - 1, b);
                chk(b == model[mptr], tag, int'(b), int'(model[mptr]));
                mptr = (mptr + 1) % 256;
            end
        end else begin
            chk(ack == 1'b0, (a == 7'h30) ? "R8 control read nack" : "R2 foreign read nack", int'(ack), 0);
            read_byte(1'b0, b);
            chk(b == 8'hFF, "R2 line released after nack", int'(b), 8'hFF);
        end
        i2c_stop();
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        logic [6:0] fa;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = exp_reset(i);
        mptr    = 0;
        rst_n   = 1'b0;
        scl     = 1'b1;
        tb_pull = 1'b0;
        strap   = 3'd0;
        wp      = 1'b0;
        repeat (10) @(negedge clk);
        chk(dut_pull == 1'b0, "R11 SDA released in reset", int'(dut_pull), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R10 / R11: read without pointer starts at location 0 after reset
        do_read(mem_addr(), 1, 1'b0, 8'h00, "R10 read from reset pointer");
        // R5: header bytes and an indexed location
        do_read(mem_addr(), 3, 1'b1, 8'h00, "R5 header bytes");
        do_read(mem_addr(), 2, 1'b1, 8'd100, "R5 indexed contents");
        // R4: sequential read across the top of the array
        do_read(mem_addr(), 4, 1'b1, 8'd254, "R4 read wraps 255 to 0");

        // R1 / R2: strapped address; base address now foreign
        strap = 3'd5;
        repeat (8) @(negedge clk);
        wbuf[0] = 8'd20; wbuf[1] = 8'hAA; wbuf[2] = 8'h55;
        do_write(7'h50, 3);
        do_read(mem_addr(), 3, 1'b1, 8'd20, "R2 foreign write left memory");

        // R6: protected memory write
        wp = 1'b1;
        repeat (8) @(negedge clk);
        wbuf[0] = 8'd10; wbuf[1] = 8'h3C; wbuf[2] = 8'hC3;
        do_write(mem_addr(), 3);
        do_read(mem_addr(), 2, 1'b1, 8'd10, "R6 protected memory unchanged");

        // R8 / R10: control address under protection, then unprotected
        do_read(mem_addr(), 1, 1'b1, 8'd40, "R3 random read");
        wbuf[0] = 8'd7; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
        do_write(7'h30, 3);
        do_read(mem_addr(), 1, 1'b0, 8'h00, "R8 control write kept pointer");
        wp = 1'b0;
        repeat (8) @(negedge clk);
        do_write(7'h30, 3);
        do_read(mem_addr(), 1, 1'b0, 8'h00, "R10 pointer kept across control write");
        do_read(7'h30, 1, 1'b0, 8'h00, "R8 control read");

        // R7: unprotected write across the top of the array
        wbuf[0] = 8'd255; wbuf[1] = 8'h5A; wbuf[2] = 8'hA5;
        do_write(mem_addr(), 3);
        do_read(mem_addr(), 1, 1'b0, 8'h00, "R7 write wrap left pointer at 1");
        do_read(mem_addr(), 3, 1'b1, 8'd255, "R7 written bytes at 255 and 0");

        // Seeded random traffic
        for (int it = 0; it < 30; it++) begin
            int op;
            int n;
            op = int'($urandom % 5);
            if ($urandom % 4 == 0) strap = 3'($urandom);
            wp = 1'($urandom);
            repeat (8) @(negedge clk);
            case (op)
                0: begin
                    n = 1 + int'($urandom % 3);
                    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                    do_write(mem_addr(), n);
                end
                1: do_read(mem_addr(), 1 + int'($urandom % 4), 1'b1, 8'($urandom), "R4 sequential read data");
                2: begin
                    n = 1 + int'($urandom % 3);
                    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                    do_write(7'h30, n);
                end
                3: begin
                    do begin
                        fa = 7'($urandom);
                    end while (fa == mem_addr() || fa == 7'h30);
                    wbuf[0] = 8'($urandom); wbuf[1] = 8'($urandom);
                    do_write(fa, 2);
                end
                default: do_read(mem_addr(), 1 + int'($urandom % 2), 1'b0, 8'h00, "R10 current read data");
            endcase
        end

        finished = 1'b1;
        report();
        $finish;
    end

endmodule